// File: doc/BRIEF.md
# Color Channel Sampling Sequencer

This block steers the analog input multiplexer of a three-color image front end. It keeps a slot counter that moves forward on every sample strobe and turns the slot into a one-hot select over red, green and blue. Each sample taken is also labelled with a 2-bit channel tag, which reaches the data path one cycle later together with a valid strobe. A sync pulse, taken once per pixel group or line, returns the counter to the first channel of the active sequence.

Configuration picks between the full three-color rotation and reduced operation. Reduced operation is either one fixed channel or two channels that take turns. An order bit chooses between the forward and the reverse color order. The sync pulse normally comes straight from the rising edge of an external sync input. In the alternate format, either edge of that input can be used, and the pulse can be delayed by 0 to 7 steps of the system clock. That clock runs at twice the sample clock, so each step is half a sample period. A channel-enable pattern that cannot be used is replaced by red only, and an error flag is raised.

Top module: `color_chan_seq`

## Requirements
- R1: With `cfg_three_ch`=1 and `cfg_order_fwd`=1, each cycle with `smp_en`=1 moves the select through red, green, blue and then back to red. Channel IDs are red=0, green=1, blue=2, and `ch_sel` bit i stands for ID i.
- R2: With `cfg_three_ch`=1 and `cfg_order_fwd`=0, the rotation runs blue, green, red. In three-channel mode `cfg_chan_en` has no effect.
- R3: In the cycle after `int_sync` is high, the select is on the first channel of the active sequence: the lowest enabled ID when the order is forward, the highest when it is reverse. This applies whatever slot was current before.
- R4: With `cfg_three_ch`=0 and exactly one bit of `cfg_chan_en` set (bit0 red, bit1 green, bit2 blue), the select stays on that channel while samples are taken.
- R5: With `cfg_three_ch`=0 and exactly two enable bits set, the two channels take turns. The lower ID comes first when `cfg_order_fwd`=1 and the higher ID comes first when it is 0.
- R6: With `cfg_three_ch`=0, an enable pattern of 000 or 111 selects red only and sets `cfg_err`. In every other setting `cfg_err` is 0.
- R7: One cycle after a cycle with `smp_en`=1, `tag_valid` is 1 and `ch_tag` holds the ID that was selected during the strobe cycle. After a cycle with no strobe, `tag_valid` is 0.
- R8: With `cfg_alt_fmt`=0, `int_sync` rises in the same cycle that a rising edge of `sync_in` is first seen and lasts one cycle. Falling edges and the settings of `cfg_edge_pos` and `cfg_dly` have no effect.
- R9: With `cfg_alt_fmt`=1, `cfg_edge_pos`=1 makes rising edges of `sync_in` produce the pulse, and `cfg_edge_pos`=0 makes falling edges produce it. The other edge produces no pulse.
- R10: With `cfg_alt_fmt`=1, the pulse appears exactly `cfg_dly` clock cycles after the cycle in which the chosen edge is seen.
- R11: During and right after reset, `tag_valid`, `ch_tag`, `int_sync` and `cfg_err` are 0, and under the default configuration the select is on red.
- R12: `ch_sel` always has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the sample clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en | input | 1 | Sample strobe; moves the sequence forward one slot |
| sync_in | input | 1 | External sync level, synchronous to clk |
| cfg_three_ch | input | 1 | 1 = three-color rotation, 0 = one or two channels |
| cfg_order_fwd | input | 1 | 1 = red-to-blue order, 0 = blue-to-red order |
| cfg_chan_en | input | 3 | Enabled channels in reduced operation (bit0 red, bit1 green, bit2 blue) |
| cfg_alt_fmt | input | 1 | Turns on edge selection and sync delay |
| cfg_edge_pos | input | 1 | Sync edge in the alternate format: 1 rising, 0 falling |
| cfg_dly | input | DLY_W (3) | Sync delay in clock cycles, used in the alternate format |
| ch_sel | output | 3 | One-hot channel select |
| ch_tag | output | 2 | ID of the last sample taken |
| tag_valid | output | 1 | `ch_tag` belongs to the sample strobed in the previous cycle |
| int_sync | output | 1 | Internal sync pulse |
| cfg_err | output | 1 | The enable pattern is unusable and red is forced |

## Verification
The bench builds the block with its default `DLY_W` of 3. This gives a delay line of seven stages, so every tap from 0 to 7 can be reached, and a ten-cycle window shows the longest delay as well as the absence of a pulse from the unselected edge. The channel count is fixed at three, so every enable pattern of interest can be driven directly: single channels, each ordered pair, and both unusable patterns. The reset to the first channel is tried from slots in the middle of a sequence, for both orders.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  localparam int NCH  = 3;
  localparam int ID_W = 2;

  typedef enum logic [ID_W-1:0] {
    CH_RED = 2'd0,
    CH_GRN = 2'd1,
    CH_BLU = 2'd2
  } chan_id_e;

  // number of set bits in an enable mask
  function automatic logic [ID_W-1:0] mask_pop(input logic [NCH-1:0] m);
    logic [ID_W-1:0] acc;
    acc = '0;
    for (int k = 0; k < NCH; k++) acc = acc + ID_W'(m[k]);
    return acc;
  endfunction

  // channel held in a given slot; scan order follows the order bit,
  // and an out-of-range slot falls back to the first enabled channel
  function automatic chan_id_e slot_chan(input logic [NCH-1:0] m,
                                         input logic fwd,
                                         input logic [ID_W-1:0] slot);
    logic [ID_W-1:0] seen;
    logic [ID_W-1:0] idx;
    chan_id_e        first;
    chan_id_e        hit;
    logic            found;
    seen  = '0;
    first = CH_RED;
    hit   = CH_RED;
    found = 1'b0;
    for (int k = 0; k < NCH; k++) begin
      idx = fwd ? ID_W'(k) : ID_W'(NCH - 1 - k);
      if (m[idx]) begin
        if (seen == '0) first = chan_id_e'(idx);
        if (seen == slot) begin
          hit   = chan_id_e'(idx);
          found = 1'b1;
        end
        seen = seen + 1'b1;
      end
    end
    return found ? hit : first;
  endfunction

  function automatic logic [NCH-1:0] chan_onehot(input chan_id_e c);
    return NCH'(1) << c;
  endfunction

  // next slot with wrap at the sequence length
  function automatic logic [ID_W-1:0] slot_next(input logic [ID_W-1:0] slot,
                                                input logic [ID_W-1:0] len);
    logic [ID_W:0] inc;
    inc = {1'b0, slot} + 1'b1;
    return (inc >= {1'b0, len}) ? '0 : inc[ID_W-1:0];
  endfunction
endpackage

// File: rtl/ccs_mode_dec.sv
module ccs_mode_dec
  import ccs_pkg::*;
(
  input  logic            three_ch,
  input  logic [NCH-1:0]  chan_en,
  output logic [NCH-1:0]  mask_eff,
  output logic [ID_W-1:0] seq_len,
  output logic            err
);
  logic [ID_W-1:0] n_en;
  logic            usable;

  assign n_en   = mask_pop(chan_en);
  assign usable = (n_en == ID_W'(1)) || (n_en == ID_W'(2));

  always_comb begin
    if (three_ch) begin
      mask_eff = '1;
      seq_len  = ID_W'(NCH);
      err      = 1'b0;
    end else if (usable) begin
      mask_eff = chan_en;
      seq_len  = n_en;
      err      = 1'b0;
    end else begin
      mask_eff = NCH'(1);
      seq_len  = ID_W'(1);
      err      = 1'b1;
    end
  end
endmodule

// File: rtl/ccs_sync_gen.sv
module ccs_sync_gen #(
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  input  logic             alt_fmt,
  input  logic             edge_pos,
  input  logic [DLY_W-1:0] dly,
  output logic             edge_evt,
  output logic             sync_pulse
);
  localparam int DEPTH = (1 << DLY_W) - 1;

  logic             sync_q;
  logic             use_rise;
  logic [DLY_W-1:0] dly_eff;
  logic [DEPTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= 1'b0;
    else        sync_q <= sync_in;
  end

  assign use_rise = alt_fmt ? edge_pos : 1'b1;
  assign dly_eff  = alt_fmt ? dly : '0;
  assign edge_evt = use_rise ? (sync_in & ~sync_q) : (~sync_in & sync_q);

  generate
    if (DEPTH > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[DEPTH-2:0], edge_evt};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= edge_evt;
      end
    end
  endgenerate

  always_comb begin
    sync_pulse = edge_evt;
    for (int k = 1; k <= DEPTH; k++)
      if (dly_eff == DLY_W'(k)) sync_pulse = chain[k-1];
  end

  // R10
  dly1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && alt_fmt && dly == DLY_W'(1)) |-> (sync_pulse == $past(edge_evt)));
endmodule

// File: rtl/ccs_slot_seq.sv
module ccs_slot_seq
  import ccs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            smp_en,
  input  logic            sync_pulse,
  input  logic [NCH-1:0]  mask,
  input  logic            fwd,
  input  logic [ID_W-1:0] seq_len,
  output logic [NCH-1:0]  ch_sel,
  output chan_id_e        tag,
  output logic            tag_valid
);
  logic [ID_W-1:0] slot;
  chan_id_e        cur_id;

  always_ff @(posedge clk) begin
    if (!rst_n)          slot <= '0;
    else if (sync_pulse) slot <= '0;
    else if (smp_en)     slot <= slot_next(slot, seq_len);
  end

  assign cur_id = slot_chan(mask, fwd, slot);
  assign ch_sel = chan_onehot(cur_id);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag       <= CH_RED;
      tag_valid <= 1'b0;
    end else begin
      tag_valid <= smp_en;
      if (smp_en) tag <= cur_id;
    end
  end

  // R3
  sync_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sync_pulse) && $stable(mask) && $stable(fwd))
      |-> (ch_sel == chan_onehot(slot_chan(mask, fwd, '0))));
  // R4
  fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && seq_len == ID_W'(1) && $past(seq_len) == ID_W'(1) && $stable(mask))
      |-> $stable(ch_sel));
  // R7
  tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(smp_en)) |-> (tag_valid && tag == $past(cur_id)));
  // R12
  onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ch_sel) == 1);
endmodule

// File: rtl/color_chan_seq.sv
module color_chan_seq
  import ccs_pkg::*;
#(
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_en,
  input  logic             sync_in,
  input  logic             cfg_three_ch,
  input  logic             cfg_order_fwd,
  input  logic [NCH-1:0]   cfg_chan_en,
  input  logic             cfg_alt_fmt,
  input  logic             cfg_edge_pos,
  input  logic [DLY_W-1:0] cfg_dly,
  output logic [NCH-1:0]   ch_sel,
  output logic [ID_W-1:0]  ch_tag,
  output logic             tag_valid,
  output logic             int_sync,
  output logic             cfg_err
);
  logic [NCH-1:0]  mask_eff;
  logic [ID_W-1:0] seq_len;
  logic            edge_evt;
  chan_id_e        tag_id;

  ccs_mode_dec u_dec (
    .three_ch (cfg_three_ch),
    .chan_en  (cfg_chan_en),
    .mask_eff (mask_eff),
    .seq_len  (seq_len),
    .err      (cfg_err)
  );

  ccs_sync_gen #(.DLY_W(DLY_W)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_in    (sync_in),
    .alt_fmt    (cfg_alt_fmt),
    .edge_pos   (cfg_edge_pos),
    .dly        (cfg_dly),
    .edge_evt   (edge_evt),
    .sync_pulse (int_sync)
  );

  ccs_slot_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_en     (smp_en),
    .sync_pulse (int_sync),
    .mask       (mask_eff),
    .fwd        (cfg_order_fwd),
    .seq_len    (seq_len),
    .ch_sel     (ch_sel),
    .tag        (tag_id),
    .tag_valid  (tag_valid)
  );

  assign ch_tag = tag_id;

  // R6
  err_red_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (ch_sel == NCH'(1) && !cfg_three_ch));
  // R8
  std_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !cfg_alt_fmt && int_sync) |-> (sync_in && !$past(sync_in)));
endmodule

// File: tb/color_chan_seq_tb_top.sv
module color_chan_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       smp_en;
  logic       sync_in;
  logic       cfg_three_ch;
  logic       cfg_order_fwd;
  logic [2:0] cfg_chan_en;
  logic       cfg_alt_fmt;
  logic       cfg_edge_pos;
  logic [2:0] cfg_dly;
  logic [2:0] ch_sel;
  logic [1:0] ch_tag;
  logic       tag_valid;
  logic       int_sync;
  logic       cfg_err;

  int checks = 0;
  int fails  = 0;
  int exp_lst [3];
  int exp_n;
  int exp_err;

  always #2 clk = ~clk;

  color_chan_seq #(.DLY_W(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .sync_in(sync_in),
    .cfg_three_ch(cfg_three_ch), .cfg_order_fwd(cfg_order_fwd),
    .cfg_chan_en(cfg_chan_en), .cfg_alt_fmt(cfg_alt_fmt),
    .cfg_edge_pos(cfg_edge_pos), .cfg_dly(cfg_dly),
    .ch_sel(ch_sel), .ch_tag(ch_tag), .tag_valid(tag_valid),
    .int_sync(int_sync), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected channel list worked out from the requirement text
  task automatic build_model(input bit three, input bit [2:0] en, input bit fwd);
    int cnt;
    bit [2:0] m;
    cnt = int'(en[0]) + int'(en[1]) + int'(en[2]);
    exp_err = 0;
    if (three) m = 3'b111;
    else if (cnt == 1 || cnt == 2) m = en;
    else begin m = 3'b001; exp_err = 1; end
    exp_n = 0;
    exp_lst = '{0, 0, 0};
    for (int s = 0; s < 3; s++) begin
      int id;
      id = fwd ? s : 2 - s;
      if (m[id]) begin
        exp_lst[exp_n] = id;
        exp_n = exp_n + 1;
      end
    end
  endtask

  task automatic pulse_sync();
    @(negedge clk) sync_in = 1'b1;
    @(negedge clk) sync_in = 1'b0;
  endtask

  task automatic run_seq(input string req, input bit three, input bit [2:0] en,
                         input bit fwd, input int steps);
    @(negedge clk);
    cfg_three_ch = three; cfg_chan_en = en; cfg_order_fwd = fwd;
    cfg_alt_fmt = 1'b0; smp_en = 1'b0;
    build_model(three, en, fwd);
    pulse_sync();
    chk("R3", "first after sync", int'(ch_sel), 1 << exp_lst[0]);
    chk(req, "cfg_err", int'(cfg_err), exp_err);
    smp_en = 1'b1;
    for (int k = 1; k <= steps; k++) begin
      @(negedge clk);
      chk(req, "ch_sel", int'(ch_sel), 1 << exp_lst[k % exp_n]);
      chk("R7", "tag_valid", int'(tag_valid), 1);
      chk("R7", "ch_tag", int'(ch_tag), exp_lst[(k - 1) % exp_n]);
    end
    smp_en = 1'b0;
    @(negedge clk);
    chk("R7", "tag_valid idle", int'(tag_valid), 0);
    chk(req, "hold without strobe", int'(ch_sel), 1 << exp_lst[steps % exp_n]);
    pulse_sync();
    chk("R3", "first after mid sync", int'(ch_sel), 1 << exp_lst[0]);
  endtask

  // exp_d < 0: no pulse expected in the window
  task automatic sync_case(input string req, input bit alt, input bit epos,
                           input bit [2:0] d, input bit to_level, input int exp_d);
    @(negedge clk);
    smp_en = 1'b0;
    cfg_alt_fmt = alt; cfg_edge_pos = epos; cfg_dly = d;
    sync_in = ~to_level;
    repeat (10) @(negedge clk);
    sync_in = to_level;
    #1;
    for (int k = 0; k < 10; k++) begin
      chk(req, $sformatf("int_sync at +%0d", k), int'(int_sync), (k == exp_d) ? 1 : 0);
      @(negedge clk);
      #1;
    end
  endtask

  task automatic test_reset();
    rst_n = 1'b0; smp_en = 1'b0; sync_in = 1'b0;
    cfg_three_ch = 1'b1; cfg_order_fwd = 1'b1; cfg_chan_en = 3'b001;
    cfg_alt_fmt = 1'b0; cfg_edge_pos = 1'b0; cfg_dly = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R11", "tag_valid", int'(tag_valid), 0);
    chk("R11", "ch_tag", int'(ch_tag), 0);
    chk("R11", "int_sync", int'(int_sync), 0);
    chk("R11", "cfg_err", int'(cfg_err), 0);
    chk("R11", "ch_sel red", int'(ch_sel), 1);
  endtask

  task automatic test_illegal();
    @(negedge clk);
    cfg_three_ch = 1'b1; cfg_chan_en = 3'b000;
    #1 chk("R6", "no error in three-channel", int'(cfg_err), 0);
    cfg_three_ch = 1'b0; cfg_chan_en = 3'b111;
    #1 chk("R6", "err on 111", int'(cfg_err), 1);
    chk("R6", "red on 111", int'(ch_sel), 1);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    test_reset();
    run_seq("R1", 1'b1, 3'b000, 1'b1, 4);
    run_seq("R2", 1'b1, 3'b010, 1'b0, 4);
    run_seq("R4", 1'b0, 3'b010, 1'b1, 3);
    run_seq("R4", 1'b0, 3'b100, 1'b0, 3);
    run_seq("R5", 1'b0, 3'b110, 1'b1, 3);
    run_seq("R5", 1'b0, 3'b101, 1'b0, 3);
    run_seq("R6", 1'b0, 3'b000, 1'b1, 2);
    run_seq("R6", 1'b0, 3'b111, 1'b0, 2);
    test_illegal();
    sync_case("R8", 1'b0, 1'b0, 3'd5, 1'b1, 0);
    sync_case("R8", 1'b0, 1'b0, 3'd5, 1'b0, -1);
    sync_case("R9", 1'b1, 1'b1, 3'd0, 1'b1, 0);
    sync_case("R9", 1'b1, 1'b1, 3'd0, 1'b0, -1);
    sync_case("R9", 1'b1, 1'b0, 3'd3, 1'b0, 3);
    sync_case("R9", 1'b1, 1'b0, 3'd3, 1'b1, -1);
    sync_case("R10", 1'b1, 1'b1, 3'd7, 1'b1, 7);
    sync_case("R10", 1'b1, 1'b1, 3'd1, 1'b1, 1);
    // R12 spot check after the sync tests
    chk("R12", "single select bit", $countones(ch_sel), 1);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule